// File: doc/BRIEF.md
# Game Port Joystick Register

This block presents a joystick game port to a host as one byte-wide I/O location. Four button contacts and four axis timers share the single read value. The host starts a position measurement by writing any value to the port. It then reads the port repeatedly and measures how long each axis bit stays high.

Each axis channel is a retriggerable one-shot counter. Its pulse length comes from a per-axis duration input, counted in clock cycles. That input takes the place of the external resistor-capacitor timing. The button contacts are active low and pass through a two-flop synchroniser before they reach the read path. Read data is combinational and is valid in the same cycle as the read strobe.

Top module: `gameport_if`

## Requirements
- R1: Only bus address 0x201 (parameter `PORT_ADDR`) selects the port. A write strobe at any other address starts no measurement.
- R2: A write strobe at the port address loads all four axis counters in the same cycle. The value on `wdata_i` has no effect on the result.
- R3: Read bits 7..4 carry buttons 4..1, so bit 4 is button 1. Read bits 3..0 carry sticks 4..1, so bit 0 is stick 1. Field `dur_i[k*DUR_W +: DUR_W]` is the duration of stick k+1.
- R4: A button bit reads 1 when its contact is open (`btn_ni` high) and 0 when it is closed (`btn_ni` low). Out of reset, all four button bits read 1.
- R5: After the clock edge that takes a port write with duration D > 0, the axis bit reads 1 for exactly D cycles and then 0. Out of reset, all axis bits read 0.
- R6: A port write made while any axis is still timing reloads every counter from its current duration, so the measurement restarts.
- R7: A duration of zero leaves that axis bit at 0, with no pulse.
- R8: A change on `btn_ni` reaches the read value after the second rising clock edge following the change.
- R9: `rdata_o` is all zeros unless `rd_i` is high and the address matches in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Bus I/O address |
| wdata_i | input | 8 | Write data (not used) |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data: buttons in the upper nibble, axis timers in the lower nibble |
| btn_ni | input | 4 | Button contacts, low when closed |
| dur_i | input | 4*DUR_W | Per-axis one-shot durations in clock cycles |

## Verification
The bench builds the block with the default 16-bit address and port address 0x201, but with `DUR_W` set to 6. The narrow counter makes the all-ones duration of 63 cycles reachable in a short run, so the longest pulse is checked to its last cycle, next to zero and one-cycle pulses. Near-miss addresses 0x200 and 0x301 exercise the decode. The bench also makes rewrites at every stage of a running pulse, and at times toggles the buttons every cycle to expose the synchroniser latency.

// File: rtl/gp_pkg.sv
package gp_pkg;
  localparam int unsigned GP_AXES = 4;
  localparam int unsigned GP_BTNS = 4;

  typedef struct packed {
    logic [GP_BTNS-1:0] btn;
    logic [GP_AXES-1:0] axis;
  } gp_rd_t;
endpackage

// File: rtl/gp_decode.sv
module gp_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h201
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              rd_hit_o,
  output logic              wr_hit_o
);
  logic sel;
  assign sel      = (addr_i == PORT_ADDR);
  assign rd_hit_o = rd_i & sel;
  assign wr_hit_o = wr_i & sel;
endmodule

// File: rtl/gp_oneshot.sv
module gp_oneshot #(
  parameter int unsigned DUR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [DUR_W-1:0] dur_i,
  output logic             busy_o
);
  logic [DUR_W-1:0] cnt_q;

  // retrigger: a load always wins over the decrement
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (trig_i)         cnt_q <= dur_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/gp_sync2.sv
module gp_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gameport_if.sv
module gameport_if
  import gp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h201,
  parameter int unsigned DUR_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [7:0]               wdata_i,
  input  logic                     rd_i,
  input  logic                     wr_i,
  output logic [7:0]               rdata_o,
  input  logic [GP_BTNS-1:0]       btn_ni,
  input  logic [GP_AXES*DUR_W-1:0] dur_i
);
  logic               rd_hit, wr_hit;
  logic [GP_AXES-1:0] axis_busy;
  logic [GP_BTNS-1:0] btn_sync;
  gp_rd_t             rd_word;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i;

  gp_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .addr_i  (addr_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .rd_hit_o(rd_hit),
    .wr_hit_o(wr_hit)
  );

  for (genvar k = 0; k < GP_AXES; k++) begin : g_axis
    gp_oneshot #(.DUR_W(DUR_W)) u_os (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .trig_i(wr_hit),
      .dur_i (dur_i[k*DUR_W +: DUR_W]),
      .busy_o(axis_busy[k])
    );
  end

  // open contact is the reset state
  for (genvar k = 0; k < GP_BTNS; k++) begin : g_btn
    gp_sync2 #(.RST_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (btn_ni[k]),
      .q_o   (btn_sync[k])
    );
  end

  assign rd_word.btn  = btn_sync;
  assign rd_word.axis = axis_busy;
  assign rdata_o      = rd_hit ? rd_word : 8'h00;
endmodule

// File: rtl/gameport_if_chk.sv
module gameport_if_chk #(
  parameter int unsigned DUR_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_hit,
  input logic             wr_hit,
  input logic [3:0]       axis_busy,
  input logic [3:0]       btn_sync,
  input logic [3:0]       btn_ni,
  input logic [4*DUR_W-1:0] dur_i,
  input logic [7:0]       rdata_o
);
  logic [1:0] live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            live_q <= '0;
    else if (live_q != 2'd2) live_q <= live_q + 1'b1;
  end

  for (genvar k = 0; k < 4; k++) begin : g_ax
    // R5 R7
    load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_hit |=> (axis_busy[k] == ($past(dur_i[k*DUR_W +: DUR_W]) != '0)));
    // R2
    no_spurious_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_hit |=> !$rose(axis_busy[k]));
  end

  // R9
  idle_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit |-> (rdata_o == 8'h00));

  // R3
  read_layout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit |-> (rdata_o == {btn_sync, axis_busy}));

  // R8
  sync_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q == 2'd2) |-> (btn_sync == $past(btn_ni, 2)));
endmodule

bind gameport_if gameport_if_chk #(.DUR_W(DUR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_hit   (rd_hit),
  .wr_hit   (wr_hit),
  .axis_busy(axis_busy),
  .btn_sync (btn_sync),
  .btn_ni   (btn_ni),
  .dur_i    (dur_i),
  .rdata_o  (rdata_o)
);

// File: tb/gameport_if_tb_top.sv
module gameport_if_tb_top;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 6;
  localparam logic [AW-1:0] PA = 16'h0201;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = PA;
  logic [7:0]    wdata_i = '0;
  logic          rd_i = 1'b0;
  logic          wr_i = 1'b0;
  logic [7:0]    rdata_o;
  logic [3:0]    btn_ni = 4'hF;
  logic [4*DW-1:0] dur_i = '0;

  always #4 clk_i = ~clk_i;

  gameport_if #(.ADDR_W(AW), .PORT_ADDR(PA), .DUR_W(DW)) dut_i (.*);

  int    vecs = 0;
  int    bad = 0;
  string req = "R4";
  bit    done = 1'b0;

  // behavioural reference
  int         rem [4];
  logic [3:0] bq[$];
  logic [3:0] exp_btn;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < 4; k++) rem[k] = 0;
      bq = {4'hF};
      exp_btn = 4'hF;
    end else begin
      if (wr_i && addr_i == PA) begin
        for (int k = 0; k < 4; k++) rem[k] = int'(dur_i[k*DW +: DW]);
      end else begin
        for (int k = 0; k < 4; k++) if (rem[k] > 0) rem[k] = rem[k] - 1;
      end
      bq.push_back(btn_ni);
      exp_btn = bq.pop_front();
    end
  end

  function automatic logic [7:0] exp_rd();
    logic [3:0] ax;
    for (int k = 0; k < 4; k++) ax[k] = (rem[k] > 0);
    if (rd_i && addr_i == PA) return {exp_btn, ax};
    return 8'h00;
  endfunction

  task automatic tick();
    logic [7:0] e;
    #2;
    e = exp_rd();
    vecs++;
    if (rdata_o !== e) begin
      bad++;
      $display("FAIL %s: rdata_o=%h expected %h at %0t", req, rdata_o, e, $time);
    end
    @(negedge clk_i);
  endtask

  task automatic poll(int n);
    rd_i = 1'b1; addr_i = PA;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic port_wr(logic [AW-1:0] a, logic [4*DW-1:0] d, logic [7:0] wd);
    addr_i = a; dur_i = d; wdata_i = wd; wr_i = 1'b1; rd_i = 1'b1;
    tick();
    wr_i = 1'b0; addr_i = PA;
  endtask

  function automatic logic [4*DW-1:0] pack(int d3, int d2, int d1, int d0);
    return {DW'(d3), DW'(d2), DW'(d1), DW'(d0)};
  endfunction

  initial begin
    // R4 R5: reset values
    req = "R4"; rd_i = 1'b1;
    tick(); tick();
    rst_ni = 1'b1;
    poll(3);

    // R2 R3 R5 R7: mixed durations, stick 2 zero
    req = "R5"; port_wr(PA, pack(3, 9, 0, 5), 8'hA5); poll(12);
    req = "R7"; port_wr(PA, pack(0, 0, 0, 0), 8'hFF); poll(3);
    req = "R5"; port_wr(PA, pack(1, 1, 1, 1), 8'h00); poll(3);

    // R2: same durations, different data
    req = "R2"; port_wr(PA, pack(4, 2, 6, 3), 8'h00); poll(8);
    port_wr(PA, pack(4, 2, 6, 3), 8'hFF); poll(8);

    // R6: retrigger at several points of a running pulse
    req = "R6";
    port_wr(PA, pack(4, 4, 4, 4), 8'h11); poll(2);
    port_wr(PA, pack(7, 2, 0, 5), 8'h22); poll(1);
    port_wr(PA, pack(3, 3, 3, 3), 8'h33); poll(6);

    // R1: near-miss addresses, R9: reads elsewhere
    req = "R1";
    port_wr(16'h0200, pack(10, 10, 10, 10), 8'h01); poll(3);
    port_wr(16'h0301, pack(10, 10, 10, 10), 8'h01); poll(3);
    req = "R9";
    port_wr(PA, pack(8, 8, 8, 8), 8'h00);
    addr_i = 16'h0200;
    for (int i = 0; i < 3; i++) tick();
    rd_i = 1'b0; addr_i = PA;
    for (int i = 0; i < 3; i++) tick();
    poll(4);

    // R4 R8: button levels and latency
    req = "R8";
    btn_ni = 4'b1010; poll(4);
    btn_ni = 4'b0101; poll(4);
    btn_ni = 4'b0000; poll(3);
    req = "R4"; btn_ni = 4'b1110; poll(3);
    req = "R8";
    for (int i = 0; i < 8; i++) begin
      btn_ni = (i % 2 == 0) ? 4'h3 : 4'hC;
      poll(1);
    end
    btn_ni = 4'hF; poll(3);

    // R5: longest pulse
    req = "R5"; port_wr(PA, pack(63, 62, 1, 63), 8'h5A); poll(66);

    // R3: mixed traffic
    req = "R3";
    for (int i = 0; i < 400; i++) begin
      addr_i  = ($urandom_range(0, 7) == 0) ? 16'h0203 : PA;
      rd_i    = $urandom_range(0, 3) != 0;
      wr_i    = $urandom_range(0, 9) == 0;
      wdata_i = 8'($urandom);
      dur_i   = (4*DW)'($urandom);
      btn_ni  = 4'($urandom);
      tick();
    end
    wr_i = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule